// File: doc/BRIEF.md
# Vectored Interrupt Controller with Cascade Support

The controller watches eight request lines. It latches a rising edge on any of them as a pending request, and it drives one interrupt output to the processor. When the processor sends an acknowledge pulse, the controller answers with an 8-bit vector. That vector is the highest-priority request that is not masked, added to a programmable base. Line 0 always wins and line 7 always loses.

Software talks to the block through two register addresses. The command address (`reg_sel` = 0) accepts the initialize command and the end-of-interrupt command. The data address (`reg_sel` = 1) accepts, in order, the three remaining setup words, and after that it loads the mask. Reads return the in-service register at the command address and the mask at the data address.

Two instances can be chained.
- The primary instance is told which of its lines carry a secondary controller. When it acknowledges such a line, it passes the acknowledge on through `casc_ack` and does not drive a vector itself.
- The secondary instance's interrupt output feeds the primary's line 2, and the secondary answers with its own vector.
- An acknowledge that finds no qualifying request is answered with the line-7 vector, as a spurious interrupt.

The setup sequencer has five states:
- `ST_UNINIT`: after reset.
- `ST_WAIT_BASE`: entered from any state on an initialize command.
- `ST_WAIT_CASC`: entered from `ST_WAIT_BASE` on a data write.
- `ST_WAIT_MODE`: entered from `ST_WAIT_CASC` on a data write.
- `ST_READY`: entered from `ST_WAIT_MODE` on a data write. It is left only by a new initialize command.

Top module: `irq_ctl8`

## Requirements
- R1: A command write with bit 4 and bit 0 both set starts setup. Exactly three data writes must follow, in this order: vector base, cascade word, mode word. The block is operational only after the third. Until then `int_out` stays low and acknowledges get no answer.
- R2: An initialize command clears the mask, the pending requests and the in-service register, in the same cycle it is written.
- R3: The vector for line n is {base[7:3], n}, where base is the first data word of setup.
- R4: Requests are edge-triggered. A rising edge on `irq_in[n]` while operational sets pending bit n. A line held high raises no further request after it has been acknowledged.
- R5: Once operational, a data write loads the mask. A 1 bit blocks its line from `int_out` and from acknowledge, but the request stays pending. A data-address read returns the mask.
- R6: Priority is fixed, with line 0 highest. `int_out` is high while the best unmasked pending line has higher priority than the best in-service line.
- R7: `inta` is a one-cycle pulse. With `int_out` high, the next cycle shows `vec_valid` for one cycle with the winning line's vector. The winning line moves from pending to in-service. A command-address read returns the in-service register.
- R8: A command write of 20h clears the highest-priority in-service bit.
- R9: An acknowledge while operational with `int_out` low returns {base[7:3], 7}. It sets no in-service bit, and the mask does not block it.
- R10: On the primary, a line whose bit is set in the cascade word is acknowledged through a one-cycle `casc_ack` instead of `vec_valid`, and the attached secondary supplies the vector. Masking that line on the primary blocks every secondary interrupt.
- R11: Data writes made before setup has started are ignored. They do not change the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 1 | 0 selects the command address, 1 selects the data address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | In-service register (command address) or mask (data address) |
| irq_in | input | 8 | Request lines |
| int_out | output | 1 | Interrupt to the processor |
| inta | input | 1 | Acknowledge pulse |
| vec_valid | output | 1 | Vector valid, one cycle |
| vec_out | output | 8 | Vector |
| casc_ack | output | 1 | Acknowledge passed on to a secondary controller |

## Verification
The bench goes after four corner cases, each of which a faulty design would get visibly wrong.
- **Edges latched before setup completes.** These must not fire later. A design that latches them would raise `int_out` as soon as setup finishes.
- **A request masked between interrupt and acknowledge.** This must yield the line-7 spurious vector with no in-service bit. A design without this rule would hand out a stale vector or block the acknowledge.
- **Nested priority and end-of-interrupt order.** A lower line must wait behind an in-service higher one, and end-of-interrupt must release the highest in-service bit first. A wrong end-of-interrupt order would unblock the wrong line.
- **The cascade mask.** With the cascade line masked on the primary, the secondary's request must never reach the processor. When that line is acknowledged, the secondary's vector (base plus 8) must appear in place of the primary's line-2 vector.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;

    typedef enum logic [2:0] {
        ST_UNINIT,
        ST_WAIT_BASE,
        ST_WAIT_CASC,
        ST_WAIT_MODE,
        ST_READY
    } init_state_t;

    localparam int          CMD_INIT_BIT = 4;
    localparam int          CMD_WORD4_BIT = 0;
    localparam logic [7:0]  CMD_EOI_NS = 8'h20;

endpackage

// File: rtl/irq_init_fsm.sv
module irq_init_fsm
    import irq_ctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_wr,
    input  logic       dat_wr,
    input  logic [7:0] wdata,
    output logic       ready,
    output logic       init_clr,
    output logic       base_load,
    output logic       casc_load,
    output logic       mask_load,
    output logic       eoi_req
);

    init_state_t state_q, state_d;
    logic        start;

    assign start = cmd_wr && wdata[CMD_INIT_BIT] && wdata[CMD_WORD4_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_UNINIT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (start) begin
            state_d = ST_WAIT_BASE;
        end else begin
            unique case (state_q)
                ST_UNINIT:    state_d = ST_UNINIT;
                ST_WAIT_BASE: if (dat_wr) state_d = ST_WAIT_CASC;
                ST_WAIT_CASC: if (dat_wr) state_d = ST_WAIT_MODE;
                ST_WAIT_MODE: if (dat_wr) state_d = ST_READY;
                ST_READY:     state_d = ST_READY;
                default:      state_d = ST_UNINIT;
            endcase
        end
    end

    always_comb begin
        ready     = 1'b0;
        base_load = 1'b0;
        casc_load = 1'b0;
        mask_load = 1'b0;
        eoi_req   = 1'b0;
        init_clr  = start;
        unique case (state_q)
            ST_UNINIT:    ;
            ST_WAIT_BASE: base_load = dat_wr;
            ST_WAIT_CASC: casc_load = dat_wr;
            ST_WAIT_MODE: ;
            ST_READY: begin
                ready     = 1'b1;
                mask_load = dat_wr;
                eoi_req   = cmd_wr && (wdata == CMD_EOI_NS);
            end
            default:      ;
        endcase
    end

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int N     = 8,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     bits,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        any = |bits;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (bits[i]) idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/irq_ctl8.sv
module irq_ctl8 #(
    parameter int   N_LINES    = 8,
    parameter logic IS_PRIMARY = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_sel,
    input  logic               reg_wr,
    input  logic [7:0]         reg_wdata,
    output logic [7:0]         reg_rdata,
    input  logic [N_LINES-1:0] irq_in,
    output logic               int_out,
    input  logic               inta,
    output logic               vec_valid,
    output logic [7:0]         vec_out,
    output logic               casc_ack
);

    localparam int IDX_W = $clog2(N_LINES);
    localparam int HI_W  = 8 - IDX_W;

    logic               cmd_wr, dat_wr;
    logic               ready_w, init_clr, base_load, casc_load, mask_load, eoi_req;
    logic [HI_W-1:0]    base_q;
    logic [N_LINES-1:0] casc_q, mask_q, irr_q, isr_q, prev_q;
    logic [N_LINES-1:0] rise, pend, win_bit, eoi_bit;
    logic               p_any, s_any, ack, to_sec;
    logic [IDX_W-1:0]   p_idx, s_idx;

    assign cmd_wr = reg_wr && !reg_sel;
    assign dat_wr = reg_wr && reg_sel;

    irq_init_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_wr    (cmd_wr),
        .dat_wr    (dat_wr),
        .wdata     (reg_wdata),
        .ready     (ready_w),
        .init_clr  (init_clr),
        .base_load (base_load),
        .casc_load (casc_load),
        .mask_load (mask_load),
        .eoi_req   (eoi_req)
    );

    assign rise = irq_in & ~prev_q;
    assign pend = irr_q & ~mask_q;

    irq_prio_enc #(.N(N_LINES), .IDX_W(IDX_W)) u_req_enc (
        .bits (pend), .any (p_any), .idx (p_idx)
    );
    irq_prio_enc #(.N(N_LINES), .IDX_W(IDX_W)) u_isr_enc (
        .bits (isr_q), .any (s_any), .idx (s_idx)
    );

    assign int_out = ready_w && p_any && (!s_any || (p_idx < s_idx));
    assign ack     = inta && ready_w;
    assign win_bit = (ack && int_out) ? (N_LINES'(1) << p_idx) : '0;
    assign eoi_bit = (eoi_req && s_any) ? (N_LINES'(1) << s_idx) : '0;

    generate
        if (IS_PRIMARY) begin : g_primary
            assign to_sec = casc_q[p_idx];
        end else begin : g_secondary
            assign to_sec = 1'b0;
        end
    endgenerate

    assign reg_rdata = reg_sel ? 8'(mask_q) : 8'(isr_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            base_q <= '0;
            casc_q <= '0;
            mask_q <= '0;
            irr_q  <= '0;
            isr_q  <= '0;
        end else begin
            prev_q <= irq_in;
            if (base_load) base_q <= reg_wdata[7:IDX_W];
            if (casc_load) casc_q <= reg_wdata[N_LINES-1:0];
            if (init_clr) begin
                mask_q <= '0;
                irr_q  <= '0;
                isr_q  <= '0;
            end else begin
                if (mask_load) mask_q <= reg_wdata[N_LINES-1:0];
                if (ready_w)   irr_q  <= (irr_q & ~win_bit) | rise;
                isr_q <= (isr_q & ~eoi_bit) | win_bit;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_valid <= 1'b0;
            casc_ack  <= 1'b0;
            vec_out   <= '0;
        end else begin
            vec_valid <= 1'b0;
            casc_ack  <= 1'b0;
            if (ack) begin
                if (!int_out) begin
                    vec_valid <= 1'b1;
                    vec_out   <= {base_q, IDX_W'(N_LINES - 1)};
                end else if (to_sec) begin
                    casc_ack  <= 1'b1;
                end else begin
                    vec_valid <= 1'b1;
                    vec_out   <= {base_q, p_idx};
                end
            end
        end
    end

endmodule

// File: rtl/irq_ctl8_sva.sv
module irq_ctl8_sva #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         reg_sel,
    input logic         reg_wr,
    input logic [7:0]   reg_wdata,
    input logic         inta,
    input logic         int_out,
    input logic         vec_valid,
    input logic [7:0]   vec_out,
    input logic         ready,
    input logic         eoi,
    input logic [N-1:0] irr,
    input logic [N-1:0] isr,
    input logic [N-1:0] mask
);

    localparam int IDX_W = $clog2(N);

    a_r1_quiet_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> !int_out);

    a_r2_init_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_sel && reg_wdata[4] && reg_wdata[0])
        |=> (mask == '0 && isr == '0 && irr == '0));

    a_r5_needs_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> ((irr & ~mask) != '0));

    a_r7_ack_adds_isr: assert property (@(posedge clk) disable iff (!rst_n)
        (inta && int_out && !reg_wr)
        |=> ($countones(isr) == $past($countones(isr)) + 1));

    a_r8_eoi_drops_one: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && isr != '0 && !inta)
        |=> ($countones(isr) == $past($countones(isr)) - 1));

    a_r9_spurious_vector: assert property (@(posedge clk) disable iff (!rst_n)
        (inta && ready && !int_out)
        |=> (vec_valid && vec_out[IDX_W-1:0] == IDX_W'(N - 1)));

    a_r9_spurious_no_isr: assert property (@(posedge clk) disable iff (!rst_n)
        (inta && ready && !int_out && !reg_wr) |=> $stable(isr));

endmodule

bind irq_ctl8 irq_ctl8_sva #(.N(N_LINES)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_sel   (reg_sel),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .inta      (inta),
    .int_out   (int_out),
    .vec_valid (vec_valid),
    .vec_out   (vec_out),
    .ready     (ready_w),
    .eoi       (eoi_req),
    .irr       (irr_q),
    .isr       (isr_q),
    .mask      (mask_q)
);

// File: tb/irq_ctl8_test.sv
`timescale 1ns/1ps
module irq_ctl8_test;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;
    logic rst_n;

    logic       p_sel, p_wr, s_sel, s_wr, p_inta;
    logic [7:0] p_wdata, s_wdata, p_rdata, s_rdata;
    logic [7:0] irq_p, irq_s;
    logic       p_int, s_int, p_vv, s_vv, p_casc, s_casc;
    logic [7:0] p_vec, s_vec;
    wire  [7:0] p_lines = {irq_p[7:3], s_int, irq_p[1:0]};

    irq_ctl8 #(.IS_PRIMARY(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .reg_sel(p_sel), .reg_wr(p_wr),
        .reg_wdata(p_wdata), .reg_rdata(p_rdata), .irq_in(p_lines),
        .int_out(p_int), .inta(p_inta), .vec_valid(p_vv),
        .vec_out(p_vec), .casc_ack(p_casc)
    );

    irq_ctl8 #(.IS_PRIMARY(1'b0)) sec (
        .clk(clk), .rst_n(rst_n), .reg_sel(s_sel), .reg_wr(s_wr),
        .reg_wdata(s_wdata), .reg_rdata(s_rdata), .irq_in(irq_s),
        .int_out(s_int), .inta(p_casc), .vec_valid(s_vv),
        .vec_out(s_vec), .casc_ack(s_casc)
    );

    int   n_checks = 0;
    int   n_errors = 0;
    bit   done = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] mon_act, mon_exp;
    string      mon_tag;

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: got %02h expected %02h", req, what, act, exp);
        end
    endtask

    // Scoreboard monitor: every delivered vector must match the next expected one.
    always @(negedge clk) begin
        if (rst_n && (p_vv || s_vv)) begin
            mon_act = p_vv ? p_vec : s_vec;
            n_checks++;
            if (exp_q.size() == 0) begin
                n_errors++;
                $display("FAIL R7 unexpected vector: got %02h expected none", mon_act);
            end else begin
                mon_exp = exp_q.pop_front();
                mon_tag = tag_q.pop_front();
                if (mon_act !== mon_exp) begin
                    n_errors++;
                    $display("FAIL %s vector: got %02h expected %02h", mon_tag, mon_act, mon_exp);
                end
            end
        end
    end

    task automatic wr(input bit to_sec, input bit sel, input logic [7:0] d);
        @(negedge clk);
        if (to_sec) begin s_sel = sel; s_wdata = d; s_wr = 1'b1; end
        else        begin p_sel = sel; p_wdata = d; p_wr = 1'b1; end
        @(negedge clk);
        s_wr = 1'b0;
        p_wr = 1'b0;
    endtask

    task automatic rd(input bit from_sec, input bit sel, output logic [7:0] d);
        @(negedge clk);
        if (from_sec) s_sel = sel; else p_sel = sel;
        #1;
        d = from_sec ? s_rdata : p_rdata;
    endtask

    task automatic pulse(input bit on_sec, input logic [7:0] lines);
        @(negedge clk);
        if (on_sec) irq_s = irq_s | lines; else irq_p = irq_p | lines;
        @(negedge clk);
        if (on_sec) irq_s = irq_s & ~lines; else irq_p = irq_p & ~lines;
    endtask

    task automatic ack(input logic [7:0] exp, input string req);
        exp_q.push_back(exp);
        tag_q.push_back(req);
        @(negedge clk);
        p_inta = 1'b1;
        @(negedge clk);
        p_inta = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic setup(input bit to_sec, input logic [7:0] base, input logic [7:0] casc);
        wr(to_sec, 1'b0, 8'h11);
        wr(to_sec, 1'b1, base);
        wr(to_sec, 1'b1, casc);
        wr(to_sec, 1'b1, 8'h01);
    endtask

    logic [7:0] rv;

    initial begin
        rst_n = 1'b0;
        p_sel = 1'b0; p_wr = 1'b0; p_wdata = '0; p_inta = 1'b0;
        s_sel = 1'b0; s_wr = 1'b0; s_wdata = '0;
        irq_p = '0; irq_s = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Reset state
        check("R1", "int_out after reset", {7'b0, p_int}, 8'h00);
        check("R1", "vec_valid after reset", {7'b0, p_vv}, 8'h00);

        // R11: data write and edge before setup are ignored
        wr(1'b0, 1'b1, 8'h55);
        rd(1'b0, 1'b1, rv);
        check("R11", "mask before setup", rv, 8'h00);
        pulse(1'b0, 8'h01);
        check("R1", "int_out before setup", {7'b0, p_int}, 8'h00);
        ack(8'h27, "R1");   // no answer expected before setup; entry must stay unconsumed
        check("R1", "no answer before ready", 8'(exp_q.size()), 8'h01);
        void'(exp_q.pop_front());
        void'(tag_q.pop_front());

        setup(1'b0, 8'h20, 8'h04);
        setup(1'b1, 8'h28, 8'h02);
        check("R1", "stale edge after setup", {7'b0, p_int}, 8'h00);

        // R5: mask behaviour
        wr(1'b0, 1'b1, 8'hFE);
        rd(1'b0, 1'b1, rv);
        check("R5", "mask readback", rv, 8'hFE);
        pulse(1'b0, 8'h08);
        check("R5", "masked line quiet", {7'b0, p_int}, 8'h00);
        wr(1'b0, 1'b1, 8'h00);
        check("R5", "unmask reveals pending", {7'b0, p_int}, 8'h01);
        ack(8'h23, "R3");
        rd(1'b0, 1'b0, rv);
        check("R7", "isr after ack", rv, 8'h08);
        check("R7", "int_out after ack", {7'b0, p_int}, 8'h00);

        // R6/R8: nesting and end-of-interrupt order
        pulse(1'b0, 8'h22);
        check("R6", "higher line preempts", {7'b0, p_int}, 8'h01);
        ack(8'h21, "R6");
        rd(1'b0, 1'b0, rv);
        check("R6", "nested isr", rv, 8'h0A);
        check("R6", "lower line waits", {7'b0, p_int}, 8'h00);
        wr(1'b0, 1'b0, 8'h20);
        rd(1'b0, 1'b0, rv);
        check("R8", "eoi clears highest", rv, 8'h08);
        check("R6", "line5 behind line3", {7'b0, p_int}, 8'h00);
        wr(1'b0, 1'b0, 8'h20);
        check("R8", "line5 released", {7'b0, p_int}, 8'h01);
        ack(8'h25, "R6");
        wr(1'b0, 1'b0, 8'h20);

        // R4: held level does not re-request
        @(negedge clk);
        irq_p[4] = 1'b1;
        @(negedge clk);
        check("R4", "edge raises int", {7'b0, p_int}, 8'h01);
        ack(8'h24, "R4");
        wr(1'b0, 1'b0, 8'h20);
        repeat (3) @(negedge clk);
        check("R4", "held level quiet", {7'b0, p_int}, 8'h00);
        irq_p[4] = 1'b0;

        // R9: spurious acknowledge
        pulse(1'b0, 8'h40);
        check("R9", "line6 raises int", {7'b0, p_int}, 8'h01);
        wr(1'b0, 1'b1, 8'hFF);
        check("R9", "masked before ack", {7'b0, p_int}, 8'h00);
        ack(8'h27, "R9");
        rd(1'b0, 1'b0, rv);
        check("R9", "spurious leaves isr", rv, 8'h00);
        wr(1'b0, 1'b1, 8'h00);
        ack(8'h26, "R9");
        wr(1'b0, 1'b0, 8'h20);

        // R10: cascade line masking
        wr(1'b0, 1'b1, 8'hFE);
        pulse(1'b1, 8'h01);
        check("R10", "secondary int", {7'b0, s_int}, 8'h01);
        check("R10", "cascade masked", {7'b0, p_int}, 8'h00);
        wr(1'b0, 1'b1, 8'hFA);
        check("R10", "cascade open", {7'b0, p_int}, 8'h01);
        ack(8'h28, "R10");
        rd(1'b0, 1'b0, rv);
        check("R10", "primary isr line2", rv, 8'h04);
        wr(1'b1, 1'b0, 8'h20);
        wr(1'b0, 1'b0, 8'h20);

        // R2: re-initialize clears state, new base applies
        wr(1'b0, 1'b1, 8'h01);
        pulse(1'b0, 8'h01);
        wr(1'b0, 1'b0, 8'h11);
        rd(1'b0, 1'b1, rv);
        check("R2", "mask cleared", rv, 8'h00);
        wr(1'b0, 1'b1, 8'h40);
        wr(1'b0, 1'b1, 8'h04);
        wr(1'b0, 1'b1, 8'h01);
        check("R2", "pending cleared", {7'b0, p_int}, 8'h00);
        pulse(1'b0, 8'h01);
        ack(8'h40, "R3");

        repeat (3) @(negedge clk);
        check("R7", "scoreboard drained", 8'(exp_q.size()), 8'h00);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL R1 watchdog: got hang expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule